// File: doc/BRIEF.md
# Register-Mapped Integer Square Root Coprocessor

This block is a small coprocessor that sits on a word-addressed register bus and computes the floor of the square root of an unsigned radicand. Software loads a 64-bit radicand as two 32-bit words. It then writes the 16-bit control register. That write selects whether the whole 64-bit radicand or only its low word is used, and it starts the computation at once. A busy flag in the control register shows that work is in progress. The result register reads as zero until the answer is posted, which happens a fixed number of cycles after the start.

Inside, an iterative digit-by-digit datapath resolves several root bits per clock and finishes well within the latency window. A separate latency timer alone decides when the answer becomes visible, so software sees the same timing for every radicand. Only half-word accesses to the control register are legal. Any other width is refused and reported on an error output.

Top module: `sqrt_copro`

## Requirements
- R1: After reset the mode, busy flag, radicand words and result are all zero, so the control, result and both radicand registers read 0, and `access_err` is low.
- R2: A write to word address 0 with `bus_size` = 2'b01 (half-word) stores `bus_wdata[0]` as the mode and starts an operation. A half-word read of address 0 returns the mode in bit 0, busy in bit 15 and zero in every other bit.
- R3: Busy reads 1 from the cycle after the starting write. It is still 1 after 25 further clock edges and reads 0 after the 26th edge following the start.
- R4: The result register (word address 1) reads zero from the cycle after a start until the result is posted.
- R5: With mode 1 the posted result is floor(sqrt(R)), where R is the 64-bit radicand whose low word is at word address 2 and high word at word address 3.
- R6: With mode 0 the posted result is floor(sqrt(L)), where L is the low radicand word zero-extended. The high word is ignored.
- R7: Accesses to address 0 of byte size (2'b00) or word size (2'b10) read as zero. Such writes change neither the mode nor busy, start nothing, and raise `access_err` for exactly the one cycle after the write.
- R8: A legal control write while busy abandons the running operation, restarts with the new mode and the radicand present at that moment, and reloads the 26-cycle window.
- R9: The iterative datapath has the root ready no later than the cycle in which the latency window ends.
- R10: Once posted, the result holds until the next start, whatever is written to the radicand words or to address 1. Radicand and result registers act as whole words for every access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per asserted cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address: 0 control, 1 result, 2 radicand low, 3 radicand high |
| bus_size | input | 2 | Access width: 00 byte, 01 half-word, 10 word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational, same cycle as the read strobe |
| access_err | output | 1 | One-cycle pulse after an illegal-width write to the control register |

## Verification
A timer that loads or decrements wrongly shows up as busy clearing one or more cycles early or late, at the 25th or 26th edge after a start. A result register that is not cleared at start shows up in the first read after the write. A wrong digit decision in the datapath corrupts low-order root bits, so exact roots near perfect squares and all-ones radicands show it at the first posting. A mode that is latched wrongly, or a restart that keeps the old radicand, shows up only at the posting 26 cycles later, as a root of the wrong operand.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10
   } acc_size_e;

   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_ROOT   = 1;
   localparam int unsigned REG_RAD_LO = 2;
   localparam int unsigned REG_RAD_HI = 3;

   localparam int unsigned CTRL_MODE_BIT = 0;
   localparam int unsigned CTRL_BUSY_BIT = 15;

endpackage

// File: rtl/sqrt_step.sv
// One restoring radix-2 square-root digit decision.
module sqrt_step #(
   parameter int unsigned ROOT_W = 32
)(
   input  logic [ROOT_W+1:0] rem_i,
   input  logic [ROOT_W-1:0] root_i,
   input  logic [1:0]        pair_i,
   output logic [ROOT_W+1:0] rem_o,
   output logic [ROOT_W-1:0] root_o
);
   logic [ROOT_W+1:0] shifted;
   logic [ROOT_W+1:0] trial;

   always_comb begin
      shifted = {rem_i[ROOT_W-1:0], pair_i};
      trial   = {root_i, 2'b01};
      if (shifted >= trial) begin
         rem_o  = shifted - trial;
         root_o = {root_i[ROOT_W-2:0], 1'b1};
      end else begin
         rem_o  = shifted;
         root_o = {root_i[ROOT_W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/sqrt_engine.sv
// Iterative square root, STEPS_PER_CYCLE root bits per clock.
module sqrt_engine #(
   parameter int unsigned RAD_W           = 64,
   parameter int unsigned STEPS_PER_CYCLE = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [RAD_W-1:0]     rad_i,
   output logic [RAD_W/2-1:0]   root_o,
   output logic                 done_o
);
   localparam int unsigned ROOT_W = RAD_W / 2;
   localparam int unsigned ITER   = ROOT_W / STEPS_PER_CYCLE;
   localparam int unsigned CNT_W  = $clog2(ITER + 1);
   localparam int unsigned SHIFT  = 2 * STEPS_PER_CYCLE;

   if ((RAD_W % 2) != 0) begin : g_bad_rad
      $error("sqrt_engine: RAD_W must be even");
   end
   if (STEPS_PER_CYCLE == 0 || (ROOT_W % STEPS_PER_CYCLE) != 0) begin : g_bad_steps
      $error("sqrt_engine: STEPS_PER_CYCLE must divide RAD_W/2");
   end

   logic [RAD_W-1:0]  rad_q;
   logic [ROOT_W+1:0] rem_q;
   logic [ROOT_W-1:0] root_q;
   logic [CNT_W-1:0]  cnt_q;

   logic [STEPS_PER_CYCLE:0][ROOT_W+1:0] rem_c;
   logic [STEPS_PER_CYCLE:0][ROOT_W-1:0] root_c;

   assign rem_c[0]  = rem_q;
   assign root_c[0] = root_q;

   for (genvar g = 0; g < STEPS_PER_CYCLE; g++) begin : g_chain
      sqrt_step #(.ROOT_W(ROOT_W)) i_step (
         .rem_i  (rem_c[g]),
         .root_i (root_c[g]),
         .pair_i (rad_q[RAD_W-1-2*g -: 2]),
         .rem_o  (rem_c[g+1]),
         .root_o (root_c[g+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rad_q  <= '0;
         rem_q  <= '0;
         root_q <= '0;
         cnt_q  <= '0;
      end else if (start_i) begin
         rad_q  <= rad_i;
         rem_q  <= '0;
         root_q <= '0;
         cnt_q  <= CNT_W'(ITER);
      end else if (cnt_q != '0) begin
         rad_q  <= rad_q << SHIFT;
         rem_q  <= rem_c[STEPS_PER_CYCLE];
         root_q <= root_c[STEPS_PER_CYCLE];
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign root_o = root_q;
   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sqrt_timer.sv
// Fixed-latency busy window; expire_o marks the posting cycle.
module sqrt_timer #(
   parameter int unsigned LATENCY = 26
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic expire_o
);
   localparam int unsigned CNT_W = $clog2(LATENCY + 1);

   if (LATENCY < 2) begin : g_bad_lat
      $error("sqrt_timer: LATENCY must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CNT_W'(LATENCY);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == CNT_W'(1)) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy_o   = busy_q;
   assign expire_o = busy_q && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sqrt_copro.sv
module sqrt_copro
   import sqrt_pkg::*;
#(
   parameter int unsigned ADDR_W          = 4,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned RAD_W           = 64,
   parameter int unsigned LATENCY         = 26,
   parameter int unsigned STEPS_PER_CYCLE = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              access_err
);
   localparam int unsigned ROOT_W = RAD_W / 2;
   localparam int unsigned ITER   = ROOT_W / STEPS_PER_CYCLE;

   if (RAD_W != 2 * DATA_W) begin : g_bad_width
      $error("sqrt_copro: RAD_W must be twice DATA_W");
   end
   if (DATA_W <= CTRL_BUSY_BIT) begin : g_bad_data
      $error("sqrt_copro: DATA_W too narrow for the control layout");
   end
   if (ITER + 1 > LATENCY) begin : g_bad_lat
      $error("sqrt_copro: datapath cannot finish inside LATENCY");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("sqrt_copro: ADDR_W must reach four registers");
   end

   acc_size_e         acc_size;
   logic              sel_ctrl;
   logic              start_w;
   logic              bad_wr;
   logic              mode_q;
   logic [RAD_W-1:0]  rad_q;
   logic [RAD_W-1:0]  eng_rad;
   logic [ROOT_W-1:0] result_q;
   logic [ROOT_W-1:0] eng_root;
   logic              eng_done;
   logic              busy;
   logic              expire;
   logic              err_q;
   logic [DATA_W-1:0] ctrl_word;

   assign acc_size = acc_size_e'(bus_size);
   assign sel_ctrl = bus_valid && (bus_addr == ADDR_W'(REG_CTRL));
   assign start_w  = sel_ctrl && bus_write && (acc_size == ACC_HALF);
   assign bad_wr   = sel_ctrl && bus_write && (acc_size != ACC_HALF);

   // Mode of the new operation comes straight from the starting write.
   assign eng_rad = bus_wdata[CTRL_MODE_BIT] ? rad_q
                                             : {{(RAD_W-DATA_W){1'b0}}, rad_q[DATA_W-1:0]};

   sqrt_engine #(
      .RAD_W           (RAD_W),
      .STEPS_PER_CYCLE (STEPS_PER_CYCLE)
   ) i_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_w),
      .rad_i   (eng_rad),
      .root_o  (eng_root),
      .done_o  (eng_done)
   );

   sqrt_timer #(.LATENCY(LATENCY)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_w),
      .busy_o   (busy),
      .expire_o (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 1'b0;
         rad_q    <= '0;
         result_q <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= bad_wr;
         if (start_w) begin
            mode_q   <= bus_wdata[CTRL_MODE_BIT];
            result_q <= '0;
         end else if (expire) begin
            result_q <= eng_root;
         end
         if (bus_valid && bus_write && (bus_addr == ADDR_W'(REG_RAD_LO))) begin
            rad_q[DATA_W-1:0] <= bus_wdata;
         end
         if (bus_valid && bus_write && (bus_addr == ADDR_W'(REG_RAD_HI))) begin
            rad_q[RAD_W-1:DATA_W] <= bus_wdata;
         end
      end
   end

   always_comb begin
      ctrl_word                = '0;
      ctrl_word[CTRL_MODE_BIT] = mode_q;
      ctrl_word[CTRL_BUSY_BIT] = busy;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write) begin
         case (bus_addr)
            ADDR_W'(REG_CTRL):   bus_rdata = (acc_size == ACC_HALF) ? ctrl_word : '0;
            ADDR_W'(REG_ROOT):   bus_rdata = result_q;
            ADDR_W'(REG_RAD_LO): bus_rdata = rad_q[DATA_W-1:0];
            ADDR_W'(REG_RAD_HI): bus_rdata = rad_q[RAD_W-1:DATA_W];
            default:             bus_rdata = '0;
         endcase
      end
   end

   assign access_err = err_q;
endmodule

// File: rtl/sqrt_copro_chk.sv
module sqrt_copro_chk #(
   parameter int unsigned LATENCY = 26,
   parameter int unsigned ROOT_W  = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              bad_wr_i,
   input logic              err_i,
   input logic              busy_i,
   input logic              expire_i,
   input logic              done_i,
   input logic              mode_i,
   input logic [ROOT_W-1:0] result_i
);
   localparam int unsigned CYC_W = $clog2(LATENCY + 1) + 1;

   logic [CYC_W-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (start_i) begin
         cyc_q <= CYC_W'(1);
      end else if (busy_i && cyc_q != '1) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // R3
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_i);

   // R3
   latency_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |-> (cyc_q == CYC_W'(LATENCY)));

   // R3
   busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !start_i) |=> !busy_i);

   // R4
   zero_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (result_i == '0));

   // R9
   engine_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |-> done_i);

   // R7
   bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr_i |=> err_i);

   // R7
   no_false_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_wr_i |=> !err_i);

   // R7
   bad_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr_i |=> $stable(mode_i));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !start_i) |=> $stable(result_i));
endmodule

bind sqrt_copro sqrt_copro_chk #(
   .LATENCY (LATENCY),
   .ROOT_W  (RAD_W / 2)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_w),
   .bad_wr_i (bad_wr),
   .err_i    (access_err),
   .busy_i   (busy),
   .expire_i (expire),
   .done_i   (eng_done),
   .mode_i   (mode_q),
   .result_i (result_q)
);

// File: tb/test_sqrt_copro.sv
`timescale 1ns/1ps
module test_sqrt_copro;
   localparam logic [1:0] SZ_B = 2'b00;
   localparam logic [1:0] SZ_H = 2'b01;
   localparam logic [1:0] SZ_W = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        access_err;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   sqrt_copro i_sqrt_copro (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_size   (bus_size),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .access_err (access_err)
   );

   function automatic logic [31:0] ref_root(logic [63:0] v);
      logic [31:0] r = '0;
      for (int b = 31; b >= 0; b--) begin
         logic [31:0] c;
         logic [63:0] sq;
         c  = r | (32'd1 << b);
         sq = {32'd0, c} * {32'd0, c};
         if (sq <= v) r = c;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1;
      bus_addr = 4'(a); bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input int a, input logic [1:0] sz, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0;
      bus_addr = 4'(a); bus_size = sz;
      #1;
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic run_op(input logic [63:0] rad, input logic [31:0] ctl, input string req);
      logic [31:0] v;
      logic [31:0] exp;
      exp = ctl[0] ? ref_root(rad) : ref_root({32'd0, rad[31:0]});
      wr(2, SZ_W, rad[31:0]);
      wr(3, SZ_W, rad[63:32]);
      wr(0, SZ_H, ctl);
      rd(0, SZ_H, v); check("R3 busy after start", v, {16'd0, 1'b1, 14'd0, ctl[0]});
      rd(1, SZ_W, v); check("R4 result zero at start", v, 0);
      repeat (25) @(negedge clk);
      rd(0, SZ_H, v); check("R3 busy at edge 25", v, {16'd0, 1'b1, 14'd0, ctl[0]});
      rd(1, SZ_W, v); check("R4 result zero at edge 25", v, 0);
      @(negedge clk);
      rd(0, SZ_H, v); check("R2 R3 ctrl after posting", v, {31'd0, ctl[0]});
      rd(1, SZ_W, v); check(req, v, exp);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, SZ_H, v); check("R1 ctrl", v, 0);
      rd(1, SZ_W, v); check("R1 result", v, 0);
      rd(2, SZ_W, v); check("R1 rad lo", v, 0);
      rd(3, SZ_W, v); check("R1 rad hi", v, 0);
      check("R1 access_err", access_err, 0);

      // R5 / R6 directed corners
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0001, "R5 all ones");
      run_op(64'hFFFF_FFFE_0000_0001, 32'h0000_0001, "R5 max square");
      run_op(64'hFFFF_FFFE_0000_0000, 32'h0000_0001, "R5 below max square");
      run_op(64'h0, 32'h0000_8001, "R5 zero, busy bit written");
      run_op(64'hDEAD_BEEF_FFFF_FFFF, 32'h0000_FFFE, "R6 high word ignored");
      run_op(64'h1, 32'h0, "R6 one");
      run_op(64'h3, 32'h0, "R6 three");
      run_op(64'h4, 32'h0, "R6 four");

      // R2 mode read-back with noisy upper bits
      run_op(64'h0000_0001_0000_0000, 32'h0000_7FFF, "R5 two pow 32");
      rd(0, SZ_H, v); check("R2 mode only in bit 0", v, 32'h1);

      // R7 illegal widths
      rd(0, SZ_W, v); check("R7 word read zero", v, 0);
      rd(0, SZ_B, v); check("R7 byte read zero", v, 0);
      wr(0, SZ_W, 32'h0);
      check("R7 word write flagged", access_err, 1);
      rd(0, SZ_H, v); check("R7 word write no effect", v, 32'h1);
      @(negedge clk);
      check("R7 flag one cycle", access_err, 0);
      rd(1, SZ_W, v); check("R7 result kept", v, 32'h1_0000);
      wr(0, SZ_B, 32'h0);
      check("R7 byte write flagged", access_err, 1);
      repeat (3) @(negedge clk);
      rd(0, SZ_H, v); check("R7 byte write no start", v, 32'h1);

      // R10 hold after posting
      wr(1, SZ_W, 32'h1234_5678);
      wr(2, SZ_W, 32'h0000_0009);
      wr(3, SZ_B, 32'h0);
      rd(1, SZ_W, v); check("R10 result held", v, 32'h1_0000);
      rd(3, SZ_H, v); check("R10 byte write acts as word", v, 0);

      // R8 restart while busy
      wr(2, SZ_W, 32'hFFFF_FFFF);
      wr(3, SZ_W, 32'hFFFF_FFFF);
      wr(0, SZ_H, 32'h1);
      repeat (10) @(negedge clk);
      wr(2, SZ_W, 32'd144);
      wr(0, SZ_H, 32'h0);
      repeat (25) @(negedge clk);
      rd(0, SZ_H, v); check("R8 window reloaded", v, 32'h8000);
      rd(1, SZ_W, v); check("R8 result still zero", v, 0);
      @(negedge clk);
      rd(0, SZ_H, v); check("R8 done", v, 0);
      rd(1, SZ_W, v); check("R8 new operand root", v, 12);

      // Random operands, R5 and R6 with R9 covered by the posting
      for (int i = 0; i < 40; i++) begin
         logic [63:0] r;
         logic [31:0] c;
         r = {$urandom(), $urandom()};
         if (i % 4 == 1) r = r >> ($urandom() % 64);
         c = $urandom();
         run_op(r, c, c[0] ? "R5 R9 random" : "R6 R9 random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule